// File: doc/BRIEF.md
# Interlaced Line Address Offset Generator

This block computes the memory start address of every image line written by a camera capture path. The line order in memory can differ from the order of arrival. It tracks the current field and the parity of the current line within that field. For each arriving line it uses these two parities to pick one of four signed step codes. The chosen step, scaled by the line pitch, gives the start address of the next line. A second code places the first line of the odd field a few lines below the base. With suitable codes, two interlaced fields merge into one progressive frame, or a frame is stored bottom-up.

A field begins with a one-cycle `field_start_i` pulse, and each line begins with a one-cycle `line_start_i` pulse. One cycle after every line start, the block presents the start address of that line together with a one-cycle valid strobe. A downstream writer uses that address for the line's pixel data.

Top module: `ilo_addr_gen`

## Requirements
- R1: While reset is asserted and afterwards until the first line start, `line_vld_o` is 0 and `line_addr_o` is 0.
- R2: `line_vld_o` is high for exactly one cycle, in the cycle after each cycle in which `line_start_i` is high, and is low in every other cycle.
- R3: When the field latched at field start is even, the first line of that field gets `base_addr_i` as its address.
- R4: When the field latched at field start is odd, the first line gets `base_addr_i + (fld_ofs_i + 1) * pitch_i`. Codes 0, 1, 2 and 3 therefore mean +1, +2, +3 and +4 lines.
- R5: The field is odd exactly when `field_id_i` XOR `field_inv_i` is 1 at the field-start cycle. Changes to `field_id_i` or `field_inv_i` later in the field have no effect on the addresses of that field.
- R6: Line parity is even for the first line of each field and alternates with every line start. The step taken after a line comes from `step_ee_i` for an even line in an even field, `step_oe_i` for an odd line in an even field, `step_eo_i` for an even line in an odd field, and `step_oo_i` for an odd line in an odd field.
- R7: Step code c in the range 0 to 3 advances the address by (c+1)*pitch. Code c in the range 4 to 7 moves it back by (c-3)*pitch. Code 1 (+2 lines) in all four fields interleaves two fields into a progressive frame. Code 5 (-2 lines) reverses the order.
- R8: All address arithmetic wraps modulo 2^AW.
- R9: If `field_start_i` and `line_start_i` are high in the same cycle, that line is treated as the first line of the new field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| base_addr_i | input | AW | Frame base address |
| pitch_i | input | PW | Bytes per stored line |
| field_start_i | input | 1 | Pulse at the start of a field |
| line_start_i | input | 1 | Pulse at the start of a line |
| field_id_i | input | 1 | Incoming field identifier |
| field_inv_i | input | 1 | Inverts the meaning of field_id_i |
| fld_ofs_i | input | 2 | Odd-field first-line offset code |
| step_ee_i | input | 3 | Step code, even line, even field |
| step_oe_i | input | 3 | Step code, odd line, even field |
| step_eo_i | input | 3 | Step code, even line, odd field |
| step_oo_i | input | 3 | Step code, odd line, odd field |
| line_addr_o | output | AW | Start address of the current line |
| line_vld_o | output | 1 | One-cycle strobe marking a new line_addr_o |

## Verification
A wrong field parity shows on the first line of a field. That line then lands on the base instead of the offset position, or the reverse, one cycle after the line start. A wrong line parity or a wrong step selection does not show on that first line. It shows on the second line, because that is the first address built from a chosen step. A sign or scaling error in the step decoder misplaces every line from the second one onward. The reference model is compared against the outputs on every cycle, so each of these faults is reported within two lines of the field start.

// File: rtl/ilo_pkg.sv
package ilo_pkg;
  typedef logic [2:0] step_code_t;

  // pick step code by field/line parity
  function automatic step_code_t pick_code(
    input logic odd_field, input logic odd_line,
    input step_code_t ee, input step_code_t oe,
    input step_code_t eo, input step_code_t oo);
    case ({odd_field, odd_line})
      2'b00:   pick_code = ee;
      2'b01:   pick_code = oe;
      2'b10:   pick_code = eo;
      default: pick_code = oo;
    endcase
  endfunction
endpackage

// File: rtl/ilo_step.sv
module ilo_step #(
  parameter int AW = 32,
  parameter int PW = 16
) (
  input  logic [2:0]    code_i,
  input  logic [PW-1:0] pitch_i,
  output logic [AW-1:0] ofs_o
);
  localparam int MW = 3;
  logic [MW-1:0] mag;
  logic [AW-1:0] prod;

  assign mag  = MW'(code_i[1:0]) + MW'(1);
  assign prod = AW'(pitch_i) * AW'(mag);
  assign ofs_o = code_i[2] ? (~prod + AW'(1)) : prod;

  always_comb begin
    a_r7_mag_range: assert (mag >= MW'(1) && mag <= MW'(4));
  end
endmodule

// File: rtl/ilo_field_track.sv
module ilo_field_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic field_start_i,
  input  logic line_start_i,
  input  logic field_id_i,
  input  logic field_inv_i,
  output logic odd_field_o,
  output logic odd_line_o
);
  logic odd_field_q, odd_line_q;

  // field start overrides stored parities in the same cycle
  assign odd_field_o = field_start_i ? (field_id_i ^ field_inv_i) : odd_field_q;
  assign odd_line_o  = field_start_i ? 1'b0 : odd_line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      odd_field_q <= 1'b0;
      odd_line_q  <= 1'b0;
    end else begin
      odd_field_q <= odd_field_o;
      if (line_start_i) odd_line_q <= ~odd_line_o;
      else              odd_line_q <= odd_line_o;
    end
  end

  a_r5_field_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !field_start_i |=> $stable(odd_field_q));
  a_r6_line_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_start_i && !field_start_i) |=> (odd_line_q != $past(odd_line_q)));
  a_r6_line_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (field_start_i && !line_start_i) |=> !odd_line_q);
endmodule

// File: rtl/ilo_addr_gen.sv
module ilo_addr_gen #(
  parameter int AW = 32,
  parameter int PW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] base_addr_i,
  input  logic [PW-1:0] pitch_i,
  input  logic          field_start_i,
  input  logic          line_start_i,
  input  logic          field_id_i,
  input  logic          field_inv_i,
  input  logic [1:0]    fld_ofs_i,
  input  logic [2:0]    step_ee_i,
  input  logic [2:0]    step_oe_i,
  input  logic [2:0]    step_eo_i,
  input  logic [2:0]    step_oo_i,
  output logic [AW-1:0] line_addr_o,
  output logic          line_vld_o
);
  import ilo_pkg::*;

  logic          odd_field, odd_line;
  step_code_t    code;
  logic [AW-1:0] step_ofs, fld_ofs, field_base, cur_addr, next_q;

  ilo_field_track u_track (
    .clk_i, .rst_ni, .field_start_i, .line_start_i, .field_id_i, .field_inv_i,
    .odd_field_o(odd_field), .odd_line_o(odd_line)
  );

  assign code = pick_code(odd_field, odd_line, step_ee_i, step_oe_i, step_eo_i, step_oo_i);

  ilo_step #(.AW(AW), .PW(PW)) u_line_step (
    .code_i(code), .pitch_i(pitch_i), .ofs_o(step_ofs)
  );

  // field offset is always forward
  ilo_step #(.AW(AW), .PW(PW)) u_field_step (
    .code_i({1'b0, fld_ofs_i}), .pitch_i(pitch_i), .ofs_o(fld_ofs)
  );

  assign field_base = odd_field ? (base_addr_i + fld_ofs) : base_addr_i;
  assign cur_addr   = field_start_i ? field_base : next_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_q      <= '0;
      line_addr_o <= '0;
      line_vld_o  <= 1'b0;
    end else begin
      line_vld_o <= line_start_i;
      if (line_start_i) begin
        line_addr_o <= cur_addr;
        next_q      <= cur_addr + step_ofs;
      end else if (field_start_i) begin
        next_q <= field_base;
      end
    end
  end

  a_r2_vld_follows_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_vld_o |-> $past(line_start_i));
  a_r2_line_gives_vld: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_i |=> line_vld_o);
  a_r2_addr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_start_i |=> $stable(line_addr_o));
  a_r3_even_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (field_start_i && !(field_id_i ^ field_inv_i)) |=> (next_q == $past(base_addr_i)) || $past(line_start_i));
endmodule

// File: tb/ilo_addr_gen_test.sv
module ilo_addr_gen_test;
  localparam int AW = 32;
  localparam int PW = 16;
  localparam longint MASK = (64'd1 << AW) - 1;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [AW-1:0] base_addr_i = '0;
  logic [PW-1:0] pitch_i = '0;
  logic field_start_i = 0, line_start_i = 0, field_id_i = 0, field_inv_i = 0;
  logic [1:0] fld_ofs_i = '0;
  logic [2:0] step_ee_i = '0, step_oe_i = '0, step_eo_i = '0, step_oo_i = '0;
  logic [AW-1:0] line_addr_o;
  logic line_vld_o;

  int checks = 0, fails = 0;
  bit m_odd_f = 0, m_odd_l = 0;
  longint m_next = 0, m_addr = 0;
  bit m_vld = 0;

  always #2.5 clk = ~clk;

  ilo_addr_gen #(.AW(AW), .PW(PW)) uut (
    .clk_i(clk), .rst_ni, .base_addr_i, .pitch_i, .field_start_i, .line_start_i,
    .field_id_i, .field_inv_i, .fld_ofs_i, .step_ee_i, .step_oe_i, .step_eo_i,
    .step_oo_i, .line_addr_o, .line_vld_o
  );

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: expected run to end, got timeout");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  function automatic longint step_lines(input int c);
    return (c < 4) ? longint'(c + 1) : -longint'(c - 3);
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive one cycle, update model, compare after the edge
  task automatic cyc(input bit fs, input bit ls, input string req);
    int c;
    @(negedge clk);
    field_start_i = fs; line_start_i = ls;
    if (fs) begin
      m_odd_f = field_id_i ^ field_inv_i;
      m_odd_l = 0;
      m_next = m_odd_f ? (longint'(base_addr_i) + (longint'(fld_ofs_i) + 1) * longint'(pitch_i)) & MASK
                       : longint'(base_addr_i);
    end
    m_vld = ls;
    if (ls) begin
      m_addr = m_next;
      c = !m_odd_f ? (!m_odd_l ? int'(step_ee_i) : int'(step_oe_i))
                   : (!m_odd_l ? int'(step_eo_i) : int'(step_oo_i));
      m_next = (m_next + step_lines(c) * longint'(pitch_i)) & MASK;
      m_odd_l = !m_odd_l;
    end
    @(posedge clk); #1;
    field_start_i = 0; line_start_i = 0;
    chk({req, " R2 vld"}, longint'(line_vld_o), longint'(m_vld));
    chk({req, " addr"}, longint'(line_addr_o), m_addr);
  endtask

  task automatic field(input bit fid, input int nlines, input string req);
    field_id_i = fid;
    cyc(1, 0, req);
    for (int i = 0; i < nlines; i++) begin
      cyc(0, 1, req);
      cyc(0, 0, req);
    end
  endtask

  task automatic codes(input int ee, input int oe, input int eo, input int oo);
    step_ee_i = 3'(ee); step_oe_i = 3'(oe); step_eo_i = 3'(eo); step_oo_i = 3'(oo);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset vld", longint'(line_vld_o), 0);
    chk("R1 reset addr", longint'(line_addr_o), 0);
    @(negedge clk); rst_ni = 1;
    cyc(0, 0, "R1 idle");

    // R3 R4 R7: interleave with +2 everywhere
    base_addr_i = 32'h1000_0000; pitch_i = 16'd640; codes(1, 1, 1, 1);
    fld_ofs_i = 0; field_inv_i = 0;
    field(0, 5, "R3 R7 interleave even");
    field(1, 5, "R4 R7 interleave odd");

    // R7 reverse order, field inversion (R5)
    base_addr_i = 32'h2000_4000; codes(5, 5, 5, 5); field_inv_i = 1;
    field(1, 4, "R5 R7 reverse inv even");
    field(0, 4, "R5 R7 reverse inv odd");
    field_inv_i = 0;

    // R6 distinct codes per parity, R4 all field offset codes
    codes(0, 2, 6, 3);
    for (int k = 0; k < 4; k++) begin
      fld_ofs_i = 2'(k);
      field(0, 4, "R6 distinct even");
      field(1, 4, "R4 R6 distinct odd");
    end
    codes(4, 7, 3, 5);
    field(1, 6, "R6 R7 negative codes");

    // R5 mid-field changes ignored
    codes(1, 0, 2, 4);
    field_id_i = 1; cyc(1, 0, "R5 start");
    cyc(0, 1, "R5 line0");
    field_id_i = 0; field_inv_i = 1;
    cyc(0, 1, "R5 line1 after id change");
    cyc(0, 1, "R5 line2");
    field_inv_i = 0;

    // R8 wraparound up and down
    base_addr_i = 32'hFFFF_FC00; pitch_i = 16'hFFFF; codes(3, 3, 3, 3); fld_ofs_i = 3;
    field(0, 3, "R8 wrap up");
    field(1, 3, "R8 wrap odd");
    base_addr_i = 32'h0000_0100; codes(7, 7, 7, 7);
    field(0, 3, "R8 wrap down");

    // R9 simultaneous field and line start, back-to-back lines
    base_addr_i = 32'h0300_0000; pitch_i = 16'd1920; codes(1, 5, 2, 6); fld_ofs_i = 1;
    field_id_i = 1;
    cyc(1, 1, "R9 coincident odd");
    cyc(0, 1, "R9 next");
    cyc(0, 1, "R9 next2");
    field_id_i = 0;
    cyc(1, 1, "R9 coincident even");
    cyc(0, 1, "R9 follow");
    repeat (3) cyc(0, 0, "R2 idle tail");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule